// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit

This unit sits between a processor's memory-address and memory-data registers and a 16-bit, word-organised store. It carries out word and byte reads and writes one at a time. A byte read fetches the whole containing word. The unit then picks the addressed byte, sign-extends it and reports a three-bit condition code for the result. A byte write copies the low byte of the source into both byte lanes and enables only the lane that address bit 0 names.

Every access stays on the bus until the selected target raises its ready line. A fixed top slice of the address space is routed to an I/O port instead of memory. That choice sets which enable is driven and which read bus and ready line are used. A word access with an odd address is refused. It drives no enable, writes nothing, and completes with an alignment-error flag.

Top module: `byte_lane_lsu`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_done` is 0 and neither enable is high. `req_ready` is 1 only while no request is in progress, and a request is taken when `req_valid` and `req_ready` are both high at a clock edge.
- R2: A byte access drives `bus_addr` as the request address with bit 0 cleared. A word access drives the request address unchanged.
- R3: A byte load returns bits [15:8] of the word when address bit 0 is 1 and bits [7:0] when it is 0, with bit 7 of that byte copied into bits [15:8] of `rsp_data`. A word load returns the whole word.
- R4: A completed load sets `rsp_cc` from its 16-bit result as {N,Z,P}. The code is 3'b100 if bit 15 is set, 3'b010 if the result is zero, and 3'b001 otherwise. Reset gives 3'b010. Stores and refused accesses leave `rsp_cc` and `rsp_data` unchanged.
- R5: A byte store drives `bus_wdata` with the source's low byte in both lanes and `bus_be` = 2'b10 for an odd address or 2'b01 for an even one. A word store drives `bus_be` = 2'b11 and the source unchanged. Reads drive `bus_be` = 2'b11.
- R6: The enable stays high with a stable address until the target's ready is seen high; with a target latency of L cycles it is high for L+1 cycles. `rsp_done` then goes high for exactly one cycle, in the cycle after ready.
- R7: Addresses at or above 0xFE00 raise `io_en` and never `mem_en`. Their read data comes from `io_rdata` and their completion from `io_ready`. Lower addresses use `mem_en`, `mem_rdata` and `mem_ready`.
- R8: A word access with address bit 0 set raises no enable and writes nothing. It completes with `rsp_align_err` = 1 during its `rsp_done` cycle. Accepted accesses with an aligned address complete with `rsp_align_err` = 0.
- R9: `bus_we` is 1 during an access for stores and 0 for loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 16 | Byte address of the access |
| req_data | input | 16 | Store source value |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Last load result (sign-extended for bytes) |
| rsp_cc | output | 3 | Condition code {N,Z,P} of the last load |
| rsp_align_err | output | 1 | Word access was misaligned (valid with rsp_done) |
| bus_addr | output | 16 | Address to memory or I/O |
| bus_wdata | output | 16 | Write data, lane-steered |
| bus_be | output | 2 | Byte-lane write enables |
| bus_we | output | 1 | Write strobe |
| mem_en | output | 1 | Memory enable |
| mem_rdata | input | 16 | Memory read word |
| mem_ready | input | 1 | Memory access complete |
| io_en | output | 1 | I/O enable |
| io_rdata | input | 16 | I/O read word |
| io_ready | input | 1 | I/O access complete |

## Verification
The bench builds the unit with its defaults: 16-bit data and addresses, two byte lanes and the I/O slice starting at 0xFE00. With these values the sign of either lane, both lane enables, and the edge between the last memory byte at 0xFDFF and the first I/O word can all be reached with a handful of addresses. The bench's memory and I/O models have latencies it sets per test, so an enable window of one cycle and a window of several cycles are both exercised.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int LSU_DATA_W = 16;
    localparam int LSU_ADDR_W = 16;
    localparam int BYTE_W     = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_RESP   = 2'd2
    } lsu_state_e;

    typedef enum logic {
        TGT_MEM = 1'b0,
        TGT_IO  = 1'b1
    } lsu_target_e;

    // condition code layout: bit 2 negative, bit 1 zero, bit 0 positive
    localparam logic [2:0] CC_NEG  = 3'b100;
    localparam logic [2:0] CC_ZERO = 3'b010;
    localparam logic [2:0] CC_POS  = 3'b001;

    function automatic logic [2:0] cc_from(input logic neg, input logic zero);
        if (neg)       return CC_NEG;
        else if (zero) return CC_ZERO;
        else           return CC_POS;
    endfunction

endpackage

// File: rtl/lsu_addr_map.sv
module lsu_addr_map #(
    parameter int          ADDR_W  = 16,
    parameter int          LANE_W  = 1,
    parameter logic [15:0] IO_BASE = 16'hFE00
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_byte,
    output logic              is_io,
    output logic              misaligned,
    output logic [LANE_W-1:0] lane,
    output logic [ADDR_W-1:0] word_addr
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(IO_BASE);

    assign lane       = addr[LANE_W-1:0];
    assign is_io      = (addr >= BASE);
    assign misaligned = !is_byte && (lane != '0);
    assign word_addr  = is_byte ? {addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}} : addr;

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes #(
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              is_byte,
    input  logic              is_write,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wdata[i*8 +: 8] = is_byte ? src[7:0] : src[i*8 +: 8];
        assign be[i] = (is_byte && is_write) ? (lane == LANE_W'(i)) : 1'b1;
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              is_byte,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] result,
    output logic [2:0]        cc
);

    logic [BYTE_W-1:0] picked;

    always_comb begin
        picked = word[BYTE_W-1:0];
        for (int i = 0; i < LANES; i++) begin
            if (lane == LANE_W'(i)) picked = word[i*BYTE_W +: BYTE_W];
        end
    end

    assign result = is_byte ? {{(DATA_W-BYTE_W){picked[BYTE_W-1]}}, picked} : word;
    assign cc     = cc_from(result[DATA_W-1], result == '0);

endmodule

// File: rtl/byte_lane_lsu.sv
module byte_lane_lsu
    import lsu_pkg::*;
#(
    parameter int          DATA_W  = LSU_DATA_W,
    parameter int          ADDR_W  = LSU_ADDR_W,
    parameter logic [15:0] IO_BASE = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_byte,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data,
    output logic [2:0]        rsp_cc,
    output logic              rsp_align_err,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W/8-1:0] bus_be,
    output logic              bus_we,
    output logic              mem_en,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              io_en,
    input  logic [DATA_W-1:0] io_rdata,
    input  logic              io_ready
);

    localparam int LANES  = DATA_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);

    typedef struct packed {
        logic              write;
        logic              is_byte;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } req_t;

    lsu_state_e        state_q;
    req_t              req_q;
    logic [DATA_W-1:0] rsp_data_q;
    logic [2:0]        cc_q;
    logic              err_q;

    logic              is_io;
    logic              misaligned;
    logic [LANE_W-1:0] lane;
    logic [ADDR_W-1:0] word_addr;
    lsu_target_e       target;
    logic              in_access;
    logic              tgt_ready;
    logic [DATA_W-1:0] tgt_rdata;
    logic [DATA_W-1:0] ld_result;
    logic [2:0]        ld_cc;

    lsu_addr_map #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .IO_BASE(IO_BASE)
    ) u_map (
        .addr      (req_q.addr),
        .is_byte   (req_q.is_byte),
        .is_io     (is_io),
        .misaligned(misaligned),
        .lane      (lane),
        .word_addr (word_addr)
    );

    lsu_store_lanes #(
        .DATA_W(DATA_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_store (
        .is_byte (req_q.is_byte),
        .is_write(req_q.write),
        .lane    (lane),
        .src     (req_q.data),
        .wdata   (bus_wdata),
        .be      (bus_be)
    );

    lsu_load_extract #(
        .DATA_W(DATA_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_load (
        .is_byte(req_q.is_byte),
        .lane   (lane),
        .word   (tgt_rdata),
        .result (ld_result),
        .cc     (ld_cc)
    );

    assign target    = is_io ? TGT_IO : TGT_MEM;
    assign in_access = (state_q == ST_ACCESS) && !misaligned;
    assign tgt_ready = (target == TGT_IO) ? io_ready : mem_ready;
    assign tgt_rdata = (target == TGT_IO) ? io_rdata : mem_rdata;

    assign mem_en   = in_access && (target == TGT_MEM);
    assign io_en    = in_access && (target == TGT_IO);
    assign bus_addr = word_addr;
    assign bus_we   = in_access && req_q.write;

    assign req_ready     = (state_q == ST_IDLE);
    assign rsp_done      = (state_q == ST_RESP);
    assign rsp_align_err = (state_q == ST_RESP) && err_q;
    assign rsp_data      = rsp_data_q;
    assign rsp_cc        = cc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            req_q      <= '0;
            rsp_data_q <= '0;
            cc_q       <= CC_ZERO;
            err_q      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q.write   <= req_write;
                        req_q.is_byte <= req_byte;
                        req_q.addr    <= req_addr;
                        req_q.data    <= req_data;
                        state_q       <= ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (misaligned) begin
                        err_q   <= 1'b1;
                        state_q <= ST_RESP;
                    end else if (tgt_ready) begin
                        err_q <= 1'b0;
                        if (!req_q.write) begin
                            rsp_data_q <= ld_result;
                            cc_q       <= ld_cc;
                        end
                        state_q <= ST_RESP;
                    end
                end
                ST_RESP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/byte_lane_lsu_chk.sv
module byte_lane_lsu_chk #(
    parameter int          DATA_W  = 16,
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] IO_BASE = 16'hFE00
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [2:0]        rsp_cc,
    input logic              rsp_align_err,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W/8-1:0] bus_be,
    input logic              bus_we,
    input logic              mem_en,
    input logic              mem_ready,
    input logic              io_en,
    input logic              io_ready
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(IO_BASE);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_en && !io_en && !rsp_done));

    p_cc_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(rsp_cc) == 1);

    p_lane_shape_r5: assert property (@(posedge clk) disable iff (rst)
        bus_we |-> ($countones(bus_be) == 1 || bus_be == '1));

    p_mem_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_ready) |=> (mem_en && $stable(bus_addr)));

    p_io_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (io_en && !io_ready) |=> (io_en && $stable(bus_addr)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    p_done_after_ready_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && !rsp_align_err) |-> $past((mem_en && mem_ready) || (io_en && io_ready)));

    p_one_target_r7: assert property (@(posedge clk) disable iff (rst)
        !(mem_en && io_en));

    p_mem_below_r7: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (bus_addr < BASE));

    p_io_above_r7: assert property (@(posedge clk) disable iff (rst)
        io_en |-> (bus_addr >= BASE));

    p_err_no_bus_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_align_err |-> (rsp_done && $past(!mem_en && !io_en)));

endmodule

bind byte_lane_lsu byte_lane_lsu_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .IO_BASE(IO_BASE)
) u_chk (.*);

// File: tb/byte_lane_lsu_test.sv
`timescale 1ns/1ps
module byte_lane_lsu_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_byte = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic        rsp_done;
    logic [15:0] rsp_data;
    logic [2:0]  rsp_cc;
    logic        rsp_align_err;
    logic [15:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [1:0]  bus_be;
    logic        bus_we;
    logic        mem_en;
    logic [15:0] mem_rdata;
    logic        mem_ready;
    logic        io_en;
    logic [15:0] io_rdata;
    logic        io_ready;

    always #2.5 clk = ~clk;

    byte_lane_lsu uut (.*);

    // ---------------- target models ----------------
    logic [15:0] mem_arr [256];
    logic [15:0] io_arr [4];
    int mem_lat = 1;
    int io_lat  = 2;
    int mem_cnt = 0;
    int io_cnt  = 0;

    assign mem_ready = mem_en && (mem_cnt == mem_lat);
    assign io_ready  = io_en && (io_cnt == io_lat);
    assign mem_rdata = mem_arr[bus_addr[8:1]];
    assign io_rdata  = io_arr[bus_addr[2:1]];

    always @(posedge clk) begin
        mem_cnt <= (mem_en && !mem_ready) ? mem_cnt + 1 : 0;
        io_cnt  <= (io_en && !io_ready) ? io_cnt + 1 : 0;
        if (mem_en && mem_ready && bus_we) begin
            if (bus_be[0]) mem_arr[bus_addr[8:1]][7:0]  <= bus_wdata[7:0];
            if (bus_be[1]) mem_arr[bus_addr[8:1]][15:8] <= bus_wdata[15:8];
        end
        if (io_en && io_ready && bus_we) begin
            if (bus_be[0]) io_arr[bus_addr[2:1]][7:0]  <= bus_wdata[7:0];
            if (bus_be[1]) io_arr[bus_addr[2:1]][15:8] <= bus_wdata[15:8];
        end
    end

    // ---------------- bookkeeping ----------------
    int n_checks = 0;
    int n_fails  = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_cc(input logic [15:0] v);
        if (v[15]) return 3'b100;
        if (v == 16'h0) return 3'b010;
        return 3'b001;
    endfunction

    // results of the last access
    logic [15:0] got_data, seen_addr, seen_wdata;
    logic [2:0]  got_cc;
    logic [1:0]  seen_be;
    logic        got_err, seen_we, done_after, busy_ready;
    int          mem_cyc, io_cyc;

    task automatic access(input bit wr, input bit by, input logic [15:0] a, input logic [15:0] d);
        bit finished = 0;
        mem_cyc = 0; io_cyc = 0; seen_we = 0; busy_ready = 0;
        seen_addr = 'x; seen_be = 'x; seen_wdata = 'x;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_byte = by; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 0;
        for (int k = 0; k < 64; k++) begin
            if (k > 0) @(negedge clk);
            if (req_ready && !rsp_done) busy_ready = 1;
            if (mem_en) mem_cyc++;
            if (io_en) io_cyc++;
            if (mem_en || io_en) begin
                seen_addr = bus_addr; seen_be = bus_be;
                seen_wdata = bus_wdata; seen_we = bus_we;
            end
            if (rsp_done) begin
                got_data = rsp_data; got_cc = rsp_cc; got_err = rsp_align_err;
                finished = 1;
                break;
            end
        end
        if (!finished) check("R6 completion seen", 0, 1);
        @(negedge clk);
        done_after = rsp_done;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check("R1 req_ready after reset", req_ready, 1);
        check("R1 rsp_done after reset", rsp_done, 0);
        check("R1 mem_en after reset", mem_en, 0);
        check("R1 io_en after reset", io_en, 0);
        check("R4 cc after reset", rsp_cc, 3'b010);
    endtask

    task automatic t_byte_load();
        mem_arr[8'h08] = 16'h807F;
        mem_arr[8'h09] = 16'h3400;
        access(0, 1, 16'h0011, 16'h0);
        check("R3 odd byte load sign-extended", got_data, 16'hFF80);
        check("R4 cc negative", got_cc, 3'b100);
        check("R2 byte addr bit0 cleared", seen_addr, 16'h0010);
        check("R5 read be all lanes", seen_be, 2'b11);
        check("R9 load we low", seen_we, 0);
        check("R1 req_ready low while busy", busy_ready, 0);
        check("R8 aligned err low", got_err, 0);
        access(0, 1, 16'h0010, 16'h0);
        check("R3 even byte load", got_data, 16'h007F);
        check("R4 cc positive", got_cc, 3'b001);
        access(0, 1, 16'h0012, 16'h0);
        check("R3 zero byte load", got_data, 16'h0000);
        check("R4 cc zero", got_cc, 3'b010);
        access(0, 1, 16'h0013, 16'h0);
        check("R3 upper byte positive", got_data, 16'h0034);
    endtask

    task automatic t_word_load();
        access(0, 0, 16'h0010, 16'h0);
        check("R3 word load", got_data, 16'h807F);
        check("R4 word cc", got_cc, exp_cc(16'h807F));
        check("R2 word addr unchanged", seen_addr, 16'h0010);
    endtask

    task automatic t_byte_store();
        mem_arr[8'h10] = 16'h5566;
        access(1, 1, 16'h0021, 16'h12AB);
        check("R5 odd store be", seen_be, 2'b10);
        check("R5 store byte in both lanes", seen_wdata, 16'hABAB);
        check("R9 store we high", seen_we, 1);
        check("R4 store keeps cc", got_cc, 3'b100);
        check("R4 store keeps rsp_data", got_data, 16'h807F);
        access(0, 0, 16'h0020, 16'h0);
        check("R5 odd store merged", got_data, 16'hAB66);
        access(1, 1, 16'h0020, 16'h00CD);
        check("R5 even store be", seen_be, 2'b01);
        access(0, 0, 16'h0020, 16'h0);
        check("R5 even store merged", got_data, 16'hABCD);
    endtask

    task automatic t_word_store();
        access(1, 0, 16'h0030, 16'hBEEF);
        check("R5 word store be", seen_be, 2'b11);
        check("R5 word store data", seen_wdata, 16'hBEEF);
        access(0, 0, 16'h0030, 16'h0);
        check("R5 word store readback", got_data, 16'hBEEF);
    endtask

    task automatic t_latency();
        mem_lat = 0;
        access(0, 0, 16'h0030, 16'h0);
        check("R6 zero-latency enable cycles", mem_cyc, 1);
        check("R6 single done pulse", done_after, 0);
        mem_lat = 4;
        access(0, 1, 16'h0031, 16'h0);
        check("R6 long-latency enable cycles", mem_cyc, 5);
        check("R6 long-latency data", got_data, 16'hFFBE);
        check("R6 single done pulse long", done_after, 0);
        mem_lat = 1;
    endtask

    task automatic t_io();
        io_arr[2] = 16'hC3A5;
        io_arr[3] = 16'h0102;
        access(0, 0, 16'hFE04, 16'h0);
        check("R7 io read data", got_data, 16'hC3A5);
        check("R7 io read no mem_en", mem_cyc, 0);
        check("R7 io enable cycles", io_cyc, io_lat + 1);
        access(1, 1, 16'hFFFF, 16'h0077);
        check("R7 io store no mem_en", mem_cyc, 0);
        access(0, 0, 16'hFFFE, 16'h0);
        check("R7 io byte store merged", got_data, 16'h7702);
        mem_arr[8'hFF] = 16'h9911;
        access(0, 1, 16'hFDFF, 16'h0);
        check("R7 0xFDFF goes to memory", mem_cyc, 2);
        check("R7 0xFDFF no io_en", io_cyc, 0);
        check("R7 0xFDFF data", got_data, 16'hFF99);
    endtask

    task automatic t_misaligned();
        access(0, 0, 16'h0013, 16'h0);
        check("R8 misaligned load err", got_err, 1);
        check("R8 misaligned load no enable", mem_cyc + io_cyc, 0);
        check("R8 misaligned keeps rsp_data", got_data, 16'hFF99);
        access(1, 0, 16'h0031, 16'h1111);
        check("R8 misaligned store err", got_err, 1);
        access(0, 0, 16'h0030, 16'h0);
        check("R8 misaligned store wrote nothing", got_data, 16'hBEEF);
        check("R8 err clears on aligned", got_err, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_arr[i] = 16'(i * 16'h0301) ^ 16'h5A00;
        for (int i = 0; i < 4; i++) io_arr[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_byte_load();
        t_word_load();
        t_byte_store();
        t_word_store();
        t_latency();
        t_io();
        t_misaligned();
        summary();
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

endmodule